// File: doc/BRIEF.md
# Boot Image Copy Engine

This block sits next to an 8-bit processor and controls that processor's active-low reset line. After a restart it holds the processor in reset. While the processor is held, the block copies a fixed boot image from its own read-only array into external RAM. The copy starts at address 0x0000, moves upward one byte at a time, and takes three cycles for each byte: a setup cycle, a write-strobe cycle and a hold cycle.

The 16-bit RAM address is built from two halves. The low byte comes straight from the copy counter on every cycle. The high byte comes from a registered latch, and the block reloads that latch only when the counter starts a new 256-byte page. Before each page begins, the latch-enable pulse appears for one cycle. After the last byte has been written, the block releases its bus drivers and lets the processor out of reset. It then stays in an idle peripheral state and reports that the boot copy is complete.

A synchronous restart input resets the sequence at any point, including after the copy has finished, and the copy then starts again from address zero.

Top module: `boot_copier`

## Requirements
- R1: `cpuResetN` stays low from the cycle after a restart through the hold cycle of the last byte. It goes high in the cycle right after that hold cycle.
- R2: Exactly `IMG_LEN` writes take place, to addresses 0, 1, 2, ... in ascending order. The byte written to address k is ((k*37 + 11) mod 256) XOR (floor(k/256) mod 256).
- R3: `ramAddr[7:0]` is the low byte of the current copy position on every cycle of the copy. `ramAddr[15:8]` always shows the value held in the high-byte latch.
- R4: The high-byte latch changes only in the cycle after `hiLatchLe` was high. During a copy, `hiLatchLe` pulses exactly ceil(`IMG_LEN`/256) times: once at the start, and once after each write to an address whose low byte is 0xFF.
- R5: When the copy completes, `bootDone` goes high together with `cpuResetN`. Both stay high until the next restart.
- R6: Each write takes three cycles: `ramWrN` high in the setup cycle, low for exactly one cycle, then high in the hold cycle. `ramAddr` and `ramData` keep the same value across all three cycles.
- R7: The cycle after a `hiLatchLe` pulse is the setup cycle of the first write in the new page. In that cycle `ramAddr[7:0]` is 0x00 and `ramAddr[15:8]` already holds the new page number.
- R8: `busOe` is high exactly while `cpuResetN` is low. When `busOe` is low, `ramAddr` reads 0, `ramData` reads 0 and `ramWrN` reads 1.
- R9: Asserting `rstSync` in any state, including in the middle of a copy or after it has finished, restarts the copy from address 0. In the next cycle `cpuResetN` is low and `bootDone` is low.
- R10: In the cycle after `rstSync` has been sampled high, the outputs read `ramWrN`=1, `busOe`=1, `ramAddr`=0x0000 and `hiLatchLe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstSync | input | 1 | Synchronous restart of the boot sequence, active high |
| cpuResetN | output | 1 | Reset line to the processor, active low |
| bootDone | output | 1 | High once the image is copied and the block is in peripheral mode |
| busOe | output | 1 | High while the block drives the address, data and strobe lines |
| ramAddr | output | 16 | RAM address: latched high byte and directly driven low byte |
| ramData | output | 8 | Byte being written |
| ramWrN | output | 1 | RAM write strobe, active low |
| hiLatchLe | output | 1 | One-cycle enable that loads the high-address latch |

## Verification
The bench builds the block with `IMG_LEN` set to 513. At that length the copy crosses two page boundaries, and the final byte is the only byte of its page. This covers a latch reload just before a lone last write, and a release of reset that comes right after a fresh page has started. The default length of 2048 would cost thousands of cycles without adding any new boundary. The bench also restarts the block in the middle of the second page and after completion, which exercises the case where a latch already holds a nonzero page and must return to zero.

// File: rtl/boot_copier_pkg.sv
package boot_copier_pkg;

  // Strobes the sequencer sends to the datapath
  typedef struct packed {
    logic loadHi;    // load high-address latch from copy position
    logic advance;   // step copy position to next byte
    logic wrActive;  // write strobe asserted this cycle
    logic drive;     // block owns the bus
  } ctrlStrb_t;

  // Status the datapath returns to the sequencer
  typedef struct packed {
    logic lastByte;  // current position is the final image byte
    logic pageEnd;   // current low address byte is all ones
  } dpStat_t;

  typedef enum logic [2:0] {
    ST_LOADHI = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_DONE   = 3'd4
  } seqState_t;

  // Image content generator used to fill the internal array
  function automatic logic [7:0] imageByte(input int unsigned k);
    int unsigned mix;
    int unsigned page;
    mix  = k * 37 + 11;
    page = k >> 8;
    return 8'(mix) ^ 8'(page);
  endfunction

endpackage

// File: rtl/boot_copier_ctrl.sv
module boot_copier_ctrl
  import boot_copier_pkg::*;
(
  input  logic      clk,
  input  logic      rstSync,
  input  dpStat_t   stat,
  output ctrlStrb_t strb,
  output logic      cpuResetN,
  output logic      bootDone
);

  seqState_t state;
  seqState_t stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_LOADHI: stateNext = ST_SETUP;
      ST_SETUP:  stateNext = ST_STROBE;
      ST_STROBE: stateNext = ST_HOLD;
      ST_HOLD: begin
        if (stat.lastByte)     stateNext = ST_DONE;
        else if (stat.pageEnd) stateNext = ST_LOADHI;
        else                   stateNext = ST_SETUP;
      end
      ST_DONE:   stateNext = ST_DONE;
      default:   stateNext = ST_LOADHI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rstSync) state <= ST_LOADHI;
    else         state <= stateNext;
  end

  always_comb begin
    strb.loadHi   = (state == ST_LOADHI);
    strb.advance  = (state == ST_HOLD) && !stat.lastByte;
    strb.wrActive = (state == ST_STROBE);
    strb.drive    = (state != ST_DONE);
  end

  assign cpuResetN = (state == ST_DONE);
  assign bootDone  = (state == ST_DONE);

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rstSync)
    bootDone |=> bootDone && cpuResetN);  // R5

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rstSync)
    strb.wrActive |=> !strb.wrActive);  // R6

endmodule

// File: rtl/boot_copier_dp.sv
module boot_copier_dp
  import boot_copier_pkg::*;
#(
  parameter int IMG_LEN = 2048,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rstSync,
  input  ctrlStrb_t         strb,
  output dpStat_t           stat,
  output logic              busOe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramData,
  output logic              ramWrN,
  output logic              hiLatchLe
);

  localparam int LO_W   = 8;
  localparam int HI_W   = ADDR_W - LO_W;
  localparam int ROM_AW = (IMG_LEN > 1) ? $clog2(IMG_LEN) : 1;
  localparam logic [ADDR_W-1:0] LAST_POS = ADDR_W'(IMG_LEN - 1);

  logic [ADDR_W-1:0] copyPos;
  logic [HI_W-1:0]   hiLatch;
  logic [DATA_W-1:0] imageRom [IMG_LEN];
  logic [DATA_W-1:0] romOut;

  initial begin
    for (int i = 0; i < IMG_LEN; i++) imageRom[i] = DATA_W'(imageByte(i));
  end

  assign romOut = imageRom[copyPos[ROM_AW-1:0]];

  // copy position counter
  always_ff @(posedge clk) begin
    if (rstSync)           copyPos <= '0;
    else if (strb.advance) copyPos <= copyPos + 1'b1;
  end

  // high-address latch, reloaded only on its enable
  always_ff @(posedge clk) begin
    if (rstSync)          hiLatch <= '0;
    else if (strb.loadHi) hiLatch <= copyPos[ADDR_W-1:LO_W];
  end

  assign stat.lastByte = (copyPos == LAST_POS);
  assign stat.pageEnd  = (copyPos[LO_W-1:0] == {LO_W{1'b1}});

  assign busOe     = strb.drive;
  assign hiLatchLe = strb.loadHi;
  assign ramAddr   = strb.drive ? {hiLatch, copyPos[LO_W-1:0]} : '0;
  assign ramData   = strb.drive ? romOut : '0;
  assign ramWrN    = !(strb.drive && strb.wrActive);

  AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (rstSync)
    !ramWrN |=> ramWrN && $stable(ramAddr) && $stable(ramData));  // R6

  AST_SETUP_STABLE: assert property (@(posedge clk) disable iff (rstSync)
    $fell(ramWrN) |-> $stable(ramAddr) && $stable(ramData));  // R6

  AST_HI_ONLY_ON_LE: assert property (@(posedge clk) disable iff (rstSync)
    (!$past(rstSync) && !$past(hiLatchLe)) |-> $stable(hiLatch));  // R4

  AST_PAGE_START_AFTER_LE: assert property (@(posedge clk) disable iff (rstSync)
    hiLatchLe |=> (ramAddr[LO_W-1:0] == '0) && ramWrN);  // R7

  AST_ASCENDING: assert property (@(posedge clk) disable iff (rstSync)
    (!$past(rstSync) && $past(strb.advance)) |-> copyPos == $past(copyPos) + 1'b1);  // R2

  AST_RELEASED_IDLE: assert property (@(posedge clk) disable iff (rstSync)
    !busOe |-> (ramAddr == '0) && (ramData == '0) && ramWrN);  // R8

endmodule

// File: rtl/boot_copier.sv
module boot_copier
  import boot_copier_pkg::*;
#(
  parameter int IMG_LEN = 2048,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rstSync,
  output logic              cpuResetN,
  output logic              bootDone,
  output logic              busOe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramData,
  output logic              ramWrN,
  output logic              hiLatchLe
);

  ctrlStrb_t strb;
  dpStat_t   stat;

  boot_copier_ctrl u_ctrl (
    .clk       (clk),
    .rstSync   (rstSync),
    .stat      (stat),
    .strb      (strb),
    .cpuResetN (cpuResetN),
    .bootDone  (bootDone)
  );

  boot_copier_dp #(
    .IMG_LEN (IMG_LEN),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstSync   (rstSync),
    .strb      (strb),
    .stat      (stat),
    .busOe     (busOe),
    .ramAddr   (ramAddr),
    .ramData   (ramData),
    .ramWrN    (ramWrN),
    .hiLatchLe (hiLatchLe)
  );

  AST_WRITE_IN_RESET: assert property (@(posedge clk) disable iff (rstSync)
    !ramWrN |-> !cpuResetN);  // R1

  AST_OE_TRACKS_RESET: assert property (@(posedge clk) disable iff (rstSync)
    busOe == !cpuResetN);  // R8

endmodule

// File: tb/boot_copier_bench.sv
module boot_copier_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LEN        = 513;
  localparam int EXP_LE     = (LEN + 255) / 256;

  logic        clk = 1'b0;
  logic        rstSync = 1'b1;
  logic        cpuResetN, bootDone, busOe, ramWrN, hiLatchLe;
  logic [15:0] ramAddr;
  logic [7:0]  ramData;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  boot_copier #(.IMG_LEN(LEN), .ADDR_W(16), .DATA_W(8)) u_boot_copier (
    .clk       (clk),
    .rstSync   (rstSync),
    .cpuResetN (cpuResetN),
    .bootDone  (bootDone),
    .busOe     (busOe),
    .ramAddr   (ramAddr),
    .ramData   (ramData),
    .ramWrN    (ramWrN),
    .hiLatchLe (hiLatchLe)
  );

  function automatic logic [7:0] expByte(input int k);
    int m;
    m = k * 37 + 11;
    return 8'(m) ^ 8'(k >> 8);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic applyRestart();
    @(negedge clk);
    rstSync = 1'b1;
    @(negedge clk);
    #1;
    chk(cpuResetN == 1'b0, "R9 reset low after restart", int'(cpuResetN), 0);
    chk(bootDone == 1'b0, "R9 done cleared", int'(bootDone), 0);
    chk(ramWrN == 1'b1, "R10 strobe idle", int'(ramWrN), 1);
    chk(busOe == 1'b1, "R10 bus driven", int'(busOe), 1);
    chk(ramAddr == 16'h0000, "R10 address zero", int'(ramAddr), 0);
    chk(hiLatchLe == 1'b1, "R10 latch enable", int'(hiLatchLe), 1);
    @(negedge clk);
    rstSync = 1'b0;
  endtask

  // Observes one full copy, starting in the cycle where rstSync was just released
  task automatic runCopy(input string tag);
    int writes = 0;
    int les = 0;
    int lastStrobe = -10;
    int cyc = 0;
    bit prevLe = 0;
    bit prevWrN = 1;
    bit holdPend = 0;
    logic [15:0] prevAddr = '0;
    logic [7:0]  prevData = '0;
    logic [7:0]  prevHi = '0;
    bit failR1 = 0, failR8 = 0, failR4 = 0;
    #1;
    while (!bootDone && cyc < 20000) begin
      if (busOe != !cpuResetN) failR8 = 1;
      if (cpuResetN) failR1 = 1;
      if (ramAddr[15:8] != prevHi && !prevLe) failR4 = 1;
      if (holdPend) begin
        chk(ramWrN && ramAddr == prevAddr && ramData == prevData,
            "R6 hold cycle", int'(ramAddr), int'(prevAddr));
        holdPend = 0;
      end
      if (prevLe) begin
        chk(ramWrN && ramAddr[7:0] == 8'h00 && ramAddr[15:8] == 8'(writes >> 8),
            "R7 page setup after enable", int'(ramAddr), (writes >> 8) << 8);
      end
      if (!ramWrN) begin
        chk(prevWrN && ramAddr == prevAddr && ramData == prevData,
            "R6 setup cycle", int'(ramAddr), int'(prevAddr));
        chk(ramAddr == 16'(writes), "R2 R3 write address", int'(ramAddr), writes);
        chk(ramData == expByte(writes), "R2 write data", int'(ramData), int'(expByte(writes)));
        writes++;
        holdPend = 1;
        lastStrobe = cyc;
      end
      if (hiLatchLe) les++;
      prevLe = hiLatchLe;
      prevWrN = ramWrN;
      prevAddr = ramAddr;
      prevData = ramData;
      prevHi = ramAddr[15:8];
      @(negedge clk);
      #1;
      cyc++;
    end
    chk(bootDone == 1'b1, {"R5 copy completes ", tag}, int'(bootDone), 1);
    chk(!failR1, "R1 reset held during copy", int'(failR1), 0);
    chk(!failR8, "R8 bus enable follows reset", int'(failR8), 0);
    chk(!failR4, "R4 high byte moves only after enable", int'(failR4), 0);
    chk(writes == LEN, "R2 write count", writes, LEN);
    chk(les == EXP_LE, "R4 enable pulse count", les, EXP_LE);
    chk(cyc == lastStrobe + 2, "R1 release right after last hold", cyc, lastStrobe + 2);
    chk(cpuResetN == 1'b1, "R5 reset released", int'(cpuResetN), 1);
    chk(busOe == 1'b0 && ramAddr == 16'h0 && ramData == 8'h0 && ramWrN == 1'b1,
        "R8 bus released", int'(ramAddr), 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      #1;
      chk(bootDone && cpuResetN && !busOe && ramWrN, "R5 stays in peripheral mode",
          int'(bootDone), 1);
    end
  endtask

  task automatic testColdBoot();
    applyRestart();
    runCopy("cold");
  endtask

  task automatic testMidCopyRestart();
    int seen = 0;
    applyRestart();
    while (seen < 300) begin
      @(negedge clk);
      #1;
      if (!ramWrN) seen++;
    end
    chk(ramAddr[15:8] == 8'h01, "R3 second page in latch", int'(ramAddr[15:8]), 1);
    applyRestart();
    runCopy("after mid restart");
  endtask

  task automatic testRestartAfterDone();
    chk(bootDone == 1'b1, "R5 done before restart", int'(bootDone), 1);
    applyRestart();
    runCopy("after done restart");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testColdBoot();
    testMidCopyRestart();
    testRestartAfterDone();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule